// File: doc/BRIEF.md
# Seven-Wire Single-Error-Correcting Bus Codec

This block protects a 4-bit value sent over a 7-wire on-chip bus. The transmit side spreads the four data bits across wire positions 2, 4, 6 and 7. It fills the three odd positions 1, 3 and 5 with check bits. The receive side recomputes the three checks over the incoming word into a 3-bit syndrome. It turns a nonzero syndrome into the one wire position to invert, applies that fix and hands back the repaired 4-bit data. Alongside the data it reports a correction flag, the fixed position and the raw syndrome.

Both paths are plain XOR and compare logic. Each path can take optional register stages, chosen by parameters. A valid strobe travels with the data through every stage, so a cycle with no valid input yields a cycle with no valid output. Every nonzero syndrome names exactly one of the seven positions. The receiver therefore treats any nonzero syndrome as a single-bit error and repairs it.

Top module: `sec7_codec`

## Requirements
- R1: Bit i of `enc_word_o` carries wire position i+1. Data bits `enc_data_i[0]`..`enc_data_i[3]` appear unchanged at word bits 1, 3, 5 and 6 (positions 2, 4, 6, 7).
- R2: The check bits at word bits 0, 2 and 4 are data[1]^data[2]^data[3], data[0]^data[2]^data[3] and data[0]^data[1]^data[3]. For example, `enc_data_i` = 4'b0101 gives `enc_word_o` = 7'h33.
- R3: A word presented with `enc_valid_i` high appears with `enc_valid_o` high ENC_PIPE clock cycles later. The default is 1 cycle.
- R4: A received word that is a valid code word gives `dec_fix_o`=0, `dec_pos_o`=0 and `dec_syn_o`=0. `dec_data_o` then equals word bits {6,5,3,1}.
- R5: A code word with any single bit inverted, at position p (1..7), gives `dec_fix_o`=1 and `dec_pos_o`=p. `dec_data_o` then equals the original data.
- R6: `dec_syn_o` is {s1,s2,s3}, where s1 checks positions 1,4,6,7, s2 checks positions 2,3,6,7 and s3 checks positions 2,4,5,7. A single error gives these syndromes by position 1..7: 100, 011, 010, 101, 001, 110, 111.
- R7: A word presented with `dec_valid_i` high produces its result with `dec_valid_o` high DEC_PIPE_SYN+DEC_PIPE_OUT cycles later. The default is 2 cycles.
- R8: While `rst_n` is low, both valid outputs and every registered data and status output read zero.
- R9: An input cycle with its valid low produces no valid output, whatever its data lines carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipeline stages |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid_i | input | 1 | Transmit data strobe |
| enc_data_i | input | 4 | Data to encode |
| enc_valid_o | output | 1 | Encoded word strobe |
| enc_word_o | output | 7 | Encoded word, bit i drives wire position i+1 |
| dec_valid_i | input | 1 | Received word strobe |
| dec_word_i | input | 7 | Received word, bit i from wire position i+1 |
| dec_valid_o | output | 1 | Decode result strobe |
| dec_data_o | output | 4 | Repaired data |
| dec_fix_o | output | 1 | High when one bit was inverted |
| dec_pos_o | output | 3 | Repaired wire position 1..7, 0 when none |
| dec_syn_o | output | 3 | Syndrome {s1,s2,s3} |

## Verification
With default parameters, an encoded word is due one cycle after its input and a decode result two cycles after its input. Each stimulus is queued with the cycle number when its result must appear. The monitor samples at the falling edge. A result must arrive exactly in its due cycle: one that comes early, comes late or appears with no queued item counts as a failure. Idle cycles carry garbage data with the strobe low, so any result leaking out of such a cycle shows up as an unexpected valid output.

// File: rtl/sec7_pkg.sv
package sec7_pkg;

    localparam int DATA_W = 4;
    localparam int WORD_W = 7;
    localparam int SYN_W  = 3;
    localparam int POS_W  = 3;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SYN_W-1:0]  syn_t;
    typedef logic [POS_W-1:0]  pos_t;

    // Word bit index of each data bit (wire positions 2,4,6,7).
    localparam int DATA_BIT [DATA_W] = '{1, 3, 5, 6};
    // Word bit index of each check bit (wire positions 1,3,5).
    localparam int CHK_BIT  [SYN_W]  = '{0, 2, 4};
    // Word bits covered by each check; entry 0 becomes the syndrome MSB.
    localparam word_t CHK_MASK [SYN_W] = '{7'b1101001, 7'b1100110, 7'b1011010};

    function automatic syn_t syn_of(input word_t w);
        syn_t s;
        for (int k = 0; k < SYN_W; k++) begin
            s[SYN_W-1-k] = ^(w & CHK_MASK[k]);
        end
        return s;
    endfunction

    // Syndrome produced by a lone error at word bit b.
    function automatic syn_t col_of(input int b);
        word_t w;
        w = '0;
        w[b] = 1'b1;
        return syn_of(w);
    endfunction

endpackage

// File: rtl/sec7_stage.sv
module sec7_stage #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vin,
    input  logic [W-1:0] din,
    output logic         vout,
    output logic [W-1:0] dout
);

    generate
        if (EN) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vout <= 1'b0;
                    dout <= '0;
                end else begin
                    vout <= vin;
                    dout <= din;
                end
            end
        end else begin : g_wire
            assign vout = vin;
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/sec7_enc.sv
module sec7_enc
    import sec7_pkg::*;
(
    input  data_t data,
    output word_t word
);

    word_t placed;

    always_comb begin
        placed = '0;
        for (int i = 0; i < DATA_W; i++) begin
            placed[DATA_BIT[i]] = data[i];
        end
        word = placed;
        for (int k = 0; k < SYN_W; k++) begin
            word[CHK_BIT[k]] = ^(placed & CHK_MASK[k]);
        end
    end

endmodule

// File: rtl/sec7_syn.sv
module sec7_syn
    import sec7_pkg::*;
(
    input  word_t word,
    output syn_t  syn
);

    generate
        for (genvar k = 0; k < SYN_W; k++) begin : g_chk
            assign syn[SYN_W-1-k] = ^(word & CHK_MASK[k]);
        end
    endgenerate

endmodule

// File: rtl/sec7_fix.sv
module sec7_fix
    import sec7_pkg::*;
(
    input  word_t word,
    input  syn_t  syn,
    output word_t flip,
    output word_t fixed,
    output data_t data,
    output logic  fix,
    output pos_t  pos
);

    generate
        for (genvar b = 0; b < WORD_W; b++) begin : g_col
            localparam syn_t COL = col_of(b);
            assign flip[b] = (syn == COL);
        end
    endgenerate

    assign fixed = word ^ flip;
    assign fix   = (syn != '0);

    always_comb begin
        pos = '0;
        for (int b = 0; b < WORD_W; b++) begin
            if (flip[b]) pos = pos | pos_t'(b + 1);
        end
        for (int i = 0; i < DATA_W; i++) begin
            data[i] = fixed[DATA_BIT[i]];
        end
    end

endmodule

// File: rtl/sec7_codec.sv
module sec7_codec
    import sec7_pkg::*;
#(
    parameter bit ENC_PIPE     = 1'b1,
    parameter bit DEC_PIPE_SYN = 1'b1,
    parameter bit DEC_PIPE_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [WORD_W-1:0] enc_word_o,
    input  logic              dec_valid_i,
    input  logic [WORD_W-1:0] dec_word_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_fix_o,
    output logic [POS_W-1:0]  dec_pos_o,
    output logic [SYN_W-1:0]  dec_syn_o
);

    localparam int S1_W = WORD_W + SYN_W;
    localparam int S2_W = DATA_W + 1 + POS_W + SYN_W;

    // transmit path
    word_t enc_word_c;

    sec7_enc u_enc (.data(enc_data_i), .word(enc_word_c));

    sec7_stage #(.W(WORD_W), .EN(ENC_PIPE)) u_enc_stg (
        .clk(clk), .rst_n(rst_n),
        .vin(enc_valid_i), .din(enc_word_c),
        .vout(enc_valid_o), .dout(enc_word_o)
    );

    // receive path, stage 1: syndrome
    syn_t  syn_c;
    logic  s1_valid;
    word_t s1_word;
    syn_t  s1_syn;

    sec7_syn u_syn (.word(dec_word_i), .syn(syn_c));

    sec7_stage #(.W(S1_W), .EN(DEC_PIPE_SYN)) u_syn_stg (
        .clk(clk), .rst_n(rst_n),
        .vin(dec_valid_i), .din({dec_word_i, syn_c}),
        .vout(s1_valid), .dout({s1_word, s1_syn})
    );

    // receive path, stage 2: locate and repair
    word_t flip_c, fixed_c;
    data_t data_c;
    logic  fix_c;
    pos_t  pos_c;

    sec7_fix u_fix (
        .word(s1_word), .syn(s1_syn),
        .flip(flip_c), .fixed(fixed_c),
        .data(data_c), .fix(fix_c), .pos(pos_c)
    );

    sec7_stage #(.W(S2_W), .EN(DEC_PIPE_OUT)) u_out_stg (
        .clk(clk), .rst_n(rst_n),
        .vin(s1_valid), .din({data_c, fix_c, pos_c, s1_syn}),
        .vout(dec_valid_o), .dout({dec_data_o, dec_fix_o, dec_pos_o, dec_syn_o})
    );

    // checks
    p_enc_codeword_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid_o |-> (syn_of(enc_word_o) == '0));

    p_onehot_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> $onehot0(flip_c));

    p_fixed_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (syn_of(fixed_c) == '0));

    p_fix_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o |-> (dec_fix_o == (dec_pos_o != '0)));

endmodule

// File: tb/test_sec7_codec.sv
module test_sec7_codec;

    localparam int ENC_LAT = 1;
    localparam int DEC_LAT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_valid_i = 1'b0;
    logic [3:0] enc_data_i = '0;
    logic       enc_valid_o;
    logic [6:0] enc_word_o;
    logic       dec_valid_i = 1'b0;
    logic [6:0] dec_word_i = '0;
    logic       dec_valid_o;
    logic [3:0] dec_data_o;
    logic       dec_fix_o;
    logic [2:0] dec_pos_o;
    logic [2:0] dec_syn_o;

    always #4 clk = ~clk;

    sec7_codec i_sec7_codec (
        .clk(clk), .rst_n(rst_n),
        .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
        .enc_valid_o(enc_valid_o), .enc_word_o(enc_word_o),
        .dec_valid_i(dec_valid_i), .dec_word_i(dec_word_i),
        .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
        .dec_fix_o(dec_fix_o), .dec_pos_o(dec_pos_o), .dec_syn_o(dec_syn_o)
    );

    typedef struct {
        logic [6:0] word;
        int         due;
        string      tag;
    } enc_item_t;

    typedef struct {
        logic [3:0] data;
        logic       fix;
        logic [2:0] pos;
        logic [2:0] syn;
        int         due;
    } dec_item_t;

    enc_item_t enc_q[$];
    dec_item_t dec_q[$];

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // expected encoding from R1/R2
    function automatic logic [6:0] model_enc(input logic [3:0] d);
        logic [6:0] w;
        w[1] = d[0]; w[3] = d[1]; w[5] = d[2]; w[6] = d[3];
        w[0] = d[1] ^ d[2] ^ d[3];
        w[2] = d[0] ^ d[2] ^ d[3];
        w[4] = d[0] ^ d[1] ^ d[3];
        return w;
    endfunction

    // single-error syndrome table from R6, index = position
    function automatic logic [2:0] model_syn(input int p);
        case (p)
            1: return 3'b100;
            2: return 3'b011;
            3: return 3'b010;
            4: return 3'b101;
            5: return 3'b001;
            6: return 3'b110;
            7: return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    task automatic drive(input bit ev, input logic [3:0] ed, input string etag,
                         input bit dv, input logic [3:0] dd, input int p);
        logic [6:0] w;
        enc_item_t ei;
        dec_item_t di;
        @(posedge clk);
        #2;
        enc_valid_i = ev;
        enc_data_i  = ed;
        w = model_enc(dd);
        if (p != 0) w[p-1] = ~w[p-1];
        dec_valid_i = dv;
        dec_word_i  = w;
        if (ev) begin
            ei.word = model_enc(ed); ei.due = cyc + ENC_LAT; ei.tag = etag;
            enc_q.push_back(ei);
        end
        if (dv) begin
            di.data = dd; di.fix = (p != 0); di.pos = 3'(p);
            di.syn = model_syn(p); di.due = cyc + DEC_LAT;
            dec_q.push_back(di);
        end
    endtask

    // R9: idle cycle with garbage data on both inputs
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            enc_valid_i = 1'b0;
            enc_data_i  = 4'(cyc * 5 + 3);
            dec_valid_i = 1'b0;
            dec_word_i  = 7'(cyc * 37 + 11);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        enc_item_t ei;
        dec_item_t di;
        if (rst_n && !finished) begin
            if (enc_valid_o) begin
                if (enc_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected enc_valid_o", 1, 0);
                end else begin
                    ei = enc_q.pop_front();
                    chk(enc_word_o == ei.word, ei.tag, int'(enc_word_o), int'(ei.word));
                    chk(cyc == ei.due, "R3 encode latency", cyc, ei.due);
                end
            end else if (enc_q.size() != 0 && enc_q[0].due < cyc) begin
                ei = enc_q.pop_front();
                chk(1'b0, "R3 encode result missing", cyc, ei.due);
            end
            if (dec_valid_o) begin
                if (dec_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected dec_valid_o", 1, 0);
                end else begin
                    di = dec_q.pop_front();
                    chk(dec_data_o == di.data, di.fix ? "R5 data" : "R4 data",
                        int'(dec_data_o), int'(di.data));
                    chk(dec_fix_o == di.fix, di.fix ? "R5 fix flag" : "R4 fix flag",
                        int'(dec_fix_o), int'(di.fix));
                    chk(dec_pos_o == di.pos, di.fix ? "R5 position" : "R4 position",
                        int'(dec_pos_o), int'(di.pos));
                    chk(dec_syn_o == di.syn, "R6 syndrome", int'(dec_syn_o), int'(di.syn));
                    chk(cyc == di.due, "R7 decode latency", cyc, di.due);
                end
            end else if (dec_q.size() != 0 && dec_q[0].due < cyc) begin
                di = dec_q.pop_front();
                chk(1'b0, "R7 decode result missing", cyc, di.due);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog expired", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        // R8: reset state, inputs active during reset
        enc_valid_i = 1'b1; enc_data_i = 4'hF;
        dec_valid_i = 1'b1; dec_word_i = 7'h7F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(enc_valid_o == 1'b0, "R8 enc_valid_o in reset", int'(enc_valid_o), 0);
        chk(enc_word_o == '0, "R8 enc_word_o in reset", int'(enc_word_o), 0);
        chk(dec_valid_o == 1'b0, "R8 dec_valid_o in reset", int'(dec_valid_o), 0);
        chk({dec_data_o, dec_fix_o, dec_pos_o, dec_syn_o} == '0, "R8 dec outputs in reset",
            int'({dec_data_o, dec_fix_o, dec_pos_o, dec_syn_o}), 0);
        enc_valid_i = 1'b0; dec_valid_i = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // R2: worked example 4'b0101 -> 7'h33, also decoded clean
        chk(model_enc(4'b0101) == 7'h33, "R2 example model", int'(model_enc(4'b0101)), 'h33);
        drive(1'b1, 4'b0101, "R2 example word", 1'b1, 4'b0101, 0);
        idle(3);

        // R1/R4/R5: every data word, clean and with each single flip
        n = 0;
        for (int d = 0; d < 16; d++) begin
            for (int p = 0; p < 8; p++) begin
                drive(p == 0, 4'(d), "R1 encoded word", 1'b1, 4'(d), p);
                n++;
                if (n % 5 == 0) idle(1);
            end
        end

        // R3/R7 back-to-back stream with no gaps
        for (int d = 0; d < 16; d++) begin
            drive(1'b1, 4'(15 - d), "R1 encoded word", 1'b1, 4'(d), d % 8);
        end

        // R9: long idle stretch with garbage; nothing may come out
        idle(12);
        @(negedge clk);
        chk(enc_q.size() == 0, "R9 encode queue drained", enc_q.size(), 0);
        chk(dec_q.size() == 0, "R9 decode queue drained", dec_q.size(), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule